// File: doc/BRIEF.md
# Write-Guarded Serial Memory Command Front End

This block sits behind the SPI pins of a small serial memory. It decodes the host's instructions in SPI mode 0, most significant bit first. The memory holds a 128-byte nonvolatile array, a 16-byte identification area, a 64-byte scratch SRAM and a status byte. All pins are sampled with the system clock. Every nonvolatile change passes through a write-enable latch. The change is applied only when chip select returns high on a clean byte boundary. The array then stays busy for a fixed number of clocks, and while it is busy the host can only poll the status byte.

The nonvolatile cells are modelled behaviourally with a countdown busy timer. Two further instructions do not touch the array. One zeroes the whole scratch SRAM. The other sends a one-clock restart pulse to an external watchdog.

Top module: `spi_wp_mem`

## Requirements
- R1: While reset is asserted and right after it, the latch, the busy flag and the block-protect field are all zero, `miso_oe` is low and `wdt_kick` is low.
- R2: Opcode 06h, sent as exactly 8 bits and followed by chip select high, sets the latch. Opcode 04h, sent the same way, clears it. Any other bit count leaves the latch as it was. The latch reads back in status bit 1.
- R3: A data write (02h), an ID write (32h) or a status write (01h) issued while the latch is clear changes no stored byte and starts no busy period.
- R4: A data or ID write commits only if chip select rises after the opcode, one address byte and at least one whole data byte, with the bit count a multiple of 8. A status write needs at least one whole data byte after its opcode. Any other chip-select rise discards the write and keeps the latch as it was.
- R5: A committed write sets status bit 0 for WR_CYCLES clocks. When that period ends, the latch is cleared.
- R6: While status bit 0 is set, every instruction except the status read (05h) and the watchdog restart (44h) is ignored. Reads drive no data and stored bytes stay unchanged.
- R7: The data and ID writes keep the upper address bits fixed. They wrap the low 4 address bits inside a 16-byte page, and a later byte to the same location replaces an earlier one.
- R8: Status bits 3:2 protect the array. 00 protects nothing, 01 protects 60h–7Fh, 10 protects 40h–7Fh and 11 protects everything. A data write to a protected page is dropped with the latch kept. ID writes ignore these bits.
- R9: A committed status write copies bits 3:2 of its first data byte into the protect field. All its other bits are ignored.
- R10: The SRAM write (12h) and SRAM read (13h) need no latch and wrap within 64 bytes. Opcode 54h with exactly 16 bits zeroes all 64 SRAM bytes whatever its second byte holds. Any other length does nothing.
- R11: Opcode 44h produces exactly one single-clock pulse on `wdt_kick` once its eighth bit is received, even during a busy period.
- R12: The data read (03h), ID read (33h) and SRAM read shift data out MSB first after their address byte, and advance with wrap at 128, 16 and 64 bytes. The status read repeats the status byte `{0000, protect[1:0], latch, busy}`. `miso_oe` is high only in a read data phase with chip select low.
- R13: An unknown opcode has no effect until chip select rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock, mode 0 |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | High when `miso` must be driven, otherwise the pin floats |
| wdt_kick | output | 1 | One-clock watchdog restart pulse |

## Verification
A latch stuck high shows up at once in status bit 1. It also lets a write with no prior enable reach the array, which the next page read exposes. A wrong bit counter or framing decision shows in the array contents read back after the following busy period. Writes then commit after a torn frame, or the busy flag is missing from the first status poll. A busy countdown that is wrong in length or never clears the latch is seen within a few status polls. A protect field that decodes the wrong range is caught by a dropped or accepted write on the neighbouring page.

// File: rtl/spi_wp_mem.sv
module spi_wp_mem #(
  parameter int         WR_CYCLES = 200,
  parameter logic [7:0] OP_WREN   = 8'h06,
  parameter logic [7:0] OP_WRDI   = 8'h04,
  parameter logic [7:0] OP_READ   = 8'h03,
  parameter logic [7:0] OP_WRITE  = 8'h02,
  parameter logic [7:0] OP_WRSR   = 8'h01,
  parameter logic [7:0] OP_RDSR   = 8'h05,
  parameter logic [7:0] OP_IDWR   = 8'h32,
  parameter logic [7:0] OP_IDRD   = 8'h33,
  parameter logic [7:0] OP_SRWR   = 8'h12,
  parameter logic [7:0] OP_SRRD   = 8'h13,
  parameter logic [7:0] OP_CLRRAM = 8'h54,
  parameter logic [7:0] OP_KICK   = 8'h44
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic miso,
  output logic miso_oe,
  output logic wdt_kick
);
  localparam int CW = $clog2(WR_CYCLES + 1);

  typedef enum logic [3:0] {
    C_NONE, C_WREN, C_WRDI, C_READ, C_WRITE, C_WRSR,
    C_RDSR, C_IDW, C_IDR, C_SRR, C_SRW, C_CLR
  } cmd_t;

  logic [2:0] sck_p, cs_p;
  logic [1:0] mosi_p;
  cmd_t       cmd;
  logic [4:0] bitcnt;
  logic [6:0] rx, addr;
  logic [1:0] bp, bp_new;
  logic       wel, miso_r, kick;
  logic [CW-1:0] wcnt;
  logic [15:0] pval;
  logic [7:0] pbuf [16];
  logic [7:0] ee   [128];
  logic [7:0] idm  [16];
  logic [7:0] sram [64];

  wire sck_rise = sck_p[1] & ~sck_p[2];
  wire sck_fall = ~sck_p[1] & sck_p[2];
  wire cs_s     = cs_p[1];
  wire cs_rise  = cs_p[1] & ~cs_p[2];
  wire [7:0] byte_in = {rx, mosi_p[1]};
  wire [4:0] nb = (bitcnt == 5'd31) ? 5'd24 : bitcnt + 5'd1;
  wire byte_done = sck_rise && !cs_s && nb[2:0] == 3'd0;
  wire wip = wcnt != '0;
  wire [7:0] status = {4'b0000, bp, wel, wip};

  wire prot = (bp == 2'd3) || (bp == 2'd2 && addr[6]) || (bp == 2'd1 && addr[6:5] == 2'b11);
  wire ee_go  = cs_rise && cmd == C_WRITE && bitcnt == 5'd24 && wel && !prot;
  wire id_go  = cs_rise && cmd == C_IDW && bitcnt == 5'd24 && wel;
  wire st_go  = cs_rise && cmd == C_WRSR && (bitcnt == 5'd16 || bitcnt == 5'd24) && wel;
  wire clr_go = cs_rise && cmd == C_CLR && bitcnt == 5'd16;
  wire wr_start = ee_go | id_go | st_go;

  wire rd_phase = (cmd == C_RDSR && bitcnt >= 5'd8) ||
                  ((cmd == C_READ || cmd == C_IDR || cmd == C_SRR) && bitcnt >= 5'd16);

  function automatic cmd_t decode(input logic [7:0] o);
    if (o == OP_WREN)        return C_WREN;
    else if (o == OP_WRDI)   return C_WRDI;
    else if (o == OP_READ)   return C_READ;
    else if (o == OP_WRITE)  return C_WRITE;
    else if (o == OP_WRSR)   return C_WRSR;
    else if (o == OP_RDSR)   return C_RDSR;
    else if (o == OP_IDWR)   return C_IDW;
    else if (o == OP_IDRD)   return C_IDR;
    else if (o == OP_SRWR)   return C_SRW;
    else if (o == OP_SRRD)   return C_SRR;
    else if (o == OP_CLRRAM) return C_CLR;
    return C_NONE;
  endfunction

  logic [7:0] rd_byte;
  always_comb begin
    case (cmd)
      C_READ:  rd_byte = ee[addr];
      C_IDR:   rd_byte = idm[addr[3:0]];
      C_SRR:   rd_byte = sram[addr[5:0]];
      C_RDSR:  rd_byte = status;
      default: rd_byte = 8'h00;
    endcase
  end

  assign miso     = miso_r;
  assign miso_oe  = !cs_s && rd_phase;
  assign wdt_kick = kick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= 3'b000;
      cs_p   <= 3'b111;
      mosi_p <= 2'b00;
      cmd    <= C_NONE;
      bitcnt <= '0;
      rx     <= '0;
      addr   <= '0;
      bp     <= '0;
      bp_new <= '0;
      wel    <= 1'b0;
      wcnt   <= '0;
      pval   <= '0;
      miso_r <= 1'b0;
      kick   <= 1'b0;
    end else begin
      sck_p  <= {sck_p[1:0], sck};
      cs_p   <= {cs_p[1:0], cs_n};
      mosi_p <= {mosi_p[0], mosi};
      kick   <= 1'b0;

      if (cs_s) begin
        bitcnt <= '0;
        cmd    <= C_NONE;
      end else if (sck_rise) begin
        bitcnt <= nb;
        rx     <= byte_in[6:0];
      end

      if (byte_done && nb == 5'd8) begin
        cmd  <= (wip && byte_in != OP_RDSR) ? C_NONE : decode(byte_in);
        kick <= byte_in == OP_KICK;
        pval <= '0;
      end
      if (byte_done && nb == 5'd16) begin
        addr   <= byte_in[6:0];
        bp_new <= byte_in[3:2];
      end
      if (byte_done && nb == 5'd24) begin
        case (cmd)
          C_WRITE, C_IDW: begin
            pval[addr[3:0]] <= 1'b1;
            addr <= {addr[6:4], addr[3:0] + 4'd1};
          end
          C_IDR:        addr <= {addr[6:4], addr[3:0] + 4'd1};
          C_SRW, C_SRR: addr <= {addr[6], addr[5:0] + 6'd1};
          C_READ:       addr <= addr + 7'd1;
          default: ;
        endcase
      end

      if (sck_fall && !cs_s && rd_phase)
        miso_r <= rd_byte[~bitcnt[2:0]];

      if (cs_rise && bitcnt == 5'd8 && cmd == C_WREN) wel <= 1'b1;
      if (cs_rise && bitcnt == 5'd8 && cmd == C_WRDI) wel <= 1'b0;
      if (st_go) bp <= bp_new;

      if (wr_start)
        wcnt <= CW'(WR_CYCLES);
      else if (wip) begin
        wcnt <= wcnt - 1'b1;
        if (wcnt == CW'(1)) wel <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (byte_done && nb == 5'd24) begin
      if (cmd == C_WRITE || cmd == C_IDW) pbuf[addr[3:0]] <= byte_in;
      if (cmd == C_SRW) sram[addr[5:0]] <= byte_in;
    end
    if (ee_go)
      for (int i = 0; i < 16; i++)
        if (pval[i]) ee[{addr[6:4], 4'(i)}] <= pbuf[i];
    if (id_go)
      for (int i = 0; i < 16; i++)
        if (pval[i]) idm[i] <= pbuf[i];
    if (clr_go)
      for (int j = 0; j < 64; j++) sram[j] <= 8'h00;
  end
endmodule

// File: rtl/spi_wp_mem_chk.sv
module spi_wp_mem_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wel,
  input logic       wip,
  input logic       wdt_kick,
  input logic       miso_oe,
  input logic [1:0] bp,
  input logic [3:0] cmd
);
  always @(negedge clk)
    if (!rst_n) a_r1_reset_idle: assert (!wel && !wip && !wdt_kick && !miso_oe && bp == 2'd0);

  a_r3_start_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> wel);

  a_r5_latch_drops_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel);

  a_r6_busy_only_status: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> (cmd == 4'd0 || cmd == 4'd6));

  a_r9_protect_moves_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp) |-> $rose(wip));

  a_r11_single_kick: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_kick |=> !wdt_kick);
endmodule

bind spi_wp_mem spi_wp_mem_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wel(wel), .wip(wip), .wdt_kick(wdt_kick),
  .miso_oe(miso_oe), .bp(bp), .cmd(cmd)
);

// File: tb/tb_spi_wp_mem.sv
module tb_spi_wp_mem;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe, wdt_kick;
  int checks = 0, fails = 0, kicks = 0, kick_wide = 0;
  logic kick_q = 1'b0;
  bit oe_seen;
  logic [7:0] txb [80];
  logic [7:0] rxb [80];
  logic [7:0] m_ee [128];
  bit         k_ee [128];
  logic [7:0] m_id [16];
  bit         k_id [16];
  logic [7:0] m_sr [64];
  bit         m_wel = 0;
  logic [1:0] m_bp = 2'd0;
  logic [7:0] s;

  always #4 clk = ~clk;

  spi_wp_mem #(.WR_CYCLES(2000)) dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .wdt_kick(wdt_kick)
  );

  always @(posedge clk) begin
    kick_q <= wdt_kick;
    if (wdt_kick) kicks++;
    if (wdt_kick && kick_q) kick_wide++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input int nbytes, input int extra);
    oe_seen = 0;
    @(negedge clk); cs_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int b = 0; b < nbytes + (extra > 0 ? 1 : 0); b++)
      for (int k = 7; k >= 0; k--) begin
        if (b == nbytes && (7 - k) >= extra) break;
        mosi = txb[b][k];
        repeat (6) @(negedge clk);
        rxb[b][k] = miso;
        if (miso_oe) oe_seen = 1;
        sck = 1'b1;
        repeat (6) @(negedge clk);
        sck = 1'b0;
      end
    repeat (6) @(negedge clk); cs_n = 1'b1;
    repeat (10) @(negedge clk);
    if (miso_oe) oe_seen = 1;
  endtask

  task automatic op1(input logic [7:0] op);
    txb[0] = op; xfer(1, 0);
  endtask

  task automatic rdsr(output logic [7:0] st);
    txb[0] = 8'h05; txb[1] = 8'h00; xfer(2, 0); st = rxb[1];
  endtask

  function automatic logic [7:0] exp_st();
    return {4'b0000, m_bp, m_wel, 1'b0};
  endfunction

  function automatic bit m_prot(input int a);
    return m_bp == 2'd3 || (m_bp == 2'd2 && a >= 64) || (m_bp == 2'd1 && a >= 96);
  endfunction

  task automatic wait_idle();
    logic [7:0] t;
    for (int i = 0; i < 40; i++) begin
      rdsr(t);
      if (!t[0]) break;
    end
  endtask

  task automatic ee_write(input int a, input int n, input bit wren);
    if (wren) begin op1(8'h06); m_wel = 1; end
    txb[0] = 8'h02; txb[1] = 8'(a);
    for (int i = 0; i < n; i++) txb[2+i] = 8'($urandom);
    xfer(2 + n, 0);
    if (m_wel && !m_prot(a) && n > 0) begin
      for (int i = 0; i < n; i++) begin
        int d = (a & 8'h70) | ((a + i) & 15);
        m_ee[d] = txb[2+i]; k_ee[d] = 1;
      end
      m_wel = 0;
    end
    wait_idle();
  endtask

  task automatic ee_check(input int a, input int n, input string tag);
    txb[0] = 8'h03; txb[1] = 8'(a);
    for (int i = 0; i < n; i++) txb[2+i] = 8'h00;
    xfer(2 + n, 0);
    for (int i = 0; i < n; i++)
      if (k_ee[(a + i) & 127]) chk(tag, rxb[2+i], m_ee[(a + i) & 127]);
  endtask

  task automatic sr_check(input int a, input int n, input string tag);
    txb[0] = 8'h13; txb[1] = 8'(a);
    for (int i = 0; i < n; i++) txb[2+i] = 8'h00;
    xfer(2 + n, 0);
    for (int i = 0; i < n; i++) chk(tag, rxb[2+i], m_sr[(a + i) & 63]);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R5 actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int k0;
    void'($urandom(32'd4711));
    for (int i = 0; i < 128; i++) k_ee[i] = 0;
    repeat (5) @(negedge clk);
    chk("R1 oe in reset", miso_oe, 0);
    chk("R1 kick in reset", wdt_kick, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    rdsr(s); chk("R1 status after reset", s, 8'h00);

    op1(8'h06); rdsr(s); chk("R2 latch set", s, 8'h02);
    op1(8'h04); rdsr(s); chk("R2 latch cleared", s, 8'h00);
    txb[0] = 8'h06; txb[1] = 8'h00; xfer(2, 0);
    rdsr(s); chk("R2 long enable ignored", s, 8'h00);

    txb[0] = 8'hAA; txb[1] = 8'h11; txb[2] = 8'h22; xfer(3, 0);
    rdsr(s); chk("R13 unknown opcode", s, 8'h00);

    ee_write(8'h10, 16, 1); ee_check(8'h10, 16, "R7 full page");
    rdsr(s); chk("R5 latch cleared after write", s, exp_st());
    ee_write(8'h10, 4, 0); ee_check(8'h10, 16, "R3 no latch no write");
    rdsr(s); chk("R3 no busy", s, 8'h00);

    op1(8'h06); m_wel = 1;
    txb[0] = 8'h02; txb[1] = 8'h10; txb[2] = 8'h5A; txb[3] = 8'hFF; xfer(3, 3);
    rdsr(s); chk("R4 torn byte keeps latch", s, 8'h02);
    txb[0] = 8'h02; txb[1] = 8'h10; xfer(2, 0);
    rdsr(s); chk("R4 header only", s, 8'h02);
    ee_check(8'h10, 16, "R4 array unchanged");

    txb[0] = 8'h02; txb[1] = 8'h20; txb[2] = 8'h3C; xfer(3, 0);
    m_ee[8'h20] = 8'h3C; k_ee[8'h20] = 1;
    rdsr(s); chk("R5 busy and latch", s, 8'h03);
    txb[0] = 8'h03; txb[1] = 8'h20; txb[2] = 8'h00; xfer(3, 0);
    chk("R6 read during busy drives nothing", oe_seen, 0);
    op1(8'h06);
    txb[0] = 8'h02; txb[1] = 8'h30; txb[2] = 8'h99; xfer(3, 0);
    k0 = kicks; op1(8'h44);
    chk("R11 kick during busy", kicks - k0, 1);
    wait_idle(); m_wel = 0;
    rdsr(s); chk("R6 enable ignored while busy", s, 8'h00);
    ee_check(8'h20, 1, "R5 committed byte");
    chk("R6 no write while busy", k_ee[8'h30], 0);
    txb[0] = 8'h03; txb[1] = 8'h30; txb[2] = 8'h00; xfer(3, 0);
    chk("R6 busy write dropped", (rxb[2] == 8'h99) ? 1 : 0, 0);

    ee_write(8'h3E, 20, 1); ee_check(8'h30, 16, "R7 page wrap");
    ee_write(8'h7C, 6, 1);
    txb[0] = 8'h03; txb[1] = 8'h7E;
    for (int i = 2; i < 6; i++) txb[i] = 8'h00;
    xfer(6, 0);
    chk("R12 read wrap 7E", rxb[2], m_ee[126]);
    chk("R12 read wrap 00", rxb[4], m_ee[0]);

    op1(8'h06); txb[0] = 8'h01; txb[1] = 8'hFF; xfer(2, 0);
    m_bp = 2'd3; m_wel = 0; wait_idle();
    rdsr(s); chk("R9 protect all", s, 8'h0C);
    ee_write(8'h05, 3, 1); ee_check(8'h00, 16, "R8 protected page");
    rdsr(s); chk("R8 latch kept on reject", s, 8'h0E);
    txb[0] = 8'h32; txb[1] = 8'h0C;
    for (int i = 0; i < 6; i++) txb[2+i] = 8'(8'h40 + i);
    xfer(8, 0); wait_idle(); m_wel = 0;
    for (int i = 0; i < 6; i++) begin m_id[(12 + i) & 15] = 8'(8'h40 + i); k_id[(12 + i) & 15] = 1; end
    txb[0] = 8'h33; txb[1] = 8'h0C;
    for (int i = 0; i < 6; i++) txb[2+i] = 8'h00;
    xfer(8, 0);
    for (int i = 0; i < 6; i++) chk("R8 ID write ignores protect", rxb[2+i], m_id[(12 + i) & 15]);
    op1(8'h06); txb[0] = 8'h01; txb[1] = 8'hF7; xfer(2, 0);
    m_bp = 2'd1; m_wel = 0; wait_idle();
    rdsr(s); chk("R9 other bits ignored", s, 8'h04);
    ee_write(8'h50, 4, 1); ee_check(8'h50, 16, "R8 below quarter");
    ee_write(8'h70, 4, 1); ee_check(8'h70, 16, "R8 upper quarter");
    op1(8'h04); m_wel = 0;
    op1(8'h06); txb[0] = 8'h01; txb[1] = 8'h00; xfer(2, 0);
    m_bp = 2'd0; m_wel = 0; wait_idle();
    rdsr(s); chk("R9 protect cleared", s, 8'h00);

    txb[0] = 8'h12; txb[1] = 8'h00;
    for (int i = 0; i < 64; i++) begin txb[2+i] = 8'($urandom) | 8'h01; m_sr[i] = txb[2+i]; end
    xfer(66, 0);
    sr_check(0, 64, "R10 sram write");
    sr_check(60, 8, "R10 sram wrap");
    txb[0] = 8'h54; txb[1] = 8'hA5; txb[2] = 8'h00; xfer(3, 0);
    sr_check(0, 4, "R10 long clear ignored");
    txb[0] = 8'h54; txb[1] = 8'hA5; xfer(2, 0);
    for (int i = 0; i < 64; i++) m_sr[i] = 8'h00;
    sr_check(0, 64, "R10 sram cleared");

    k0 = kicks; op1(8'h06); op1(8'h04);
    chk("R11 no kick from others", kicks - k0, 0);
    op1(8'h44); chk("R11 one kick", kicks - k0, 1);
    chk("R11 single cycle", kick_wide, 0);

    txb[0] = 8'h05; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'h00; xfer(4, 0);
    chk("R12 status repeat", rxb[3], rxb[1]);
    chk("R12 oe seen in read", oe_seen, 1);
    chk("R12 oe low with cs high", miso_oe, 0);

    for (int it = 0; it < 14; it++) begin
      int a = $urandom % 128;
      int n = 1 + $urandom % 20;
      bit w = ($urandom % 4) != 0;
      ee_write(a, n, w);
      ee_check(a & 8'h70, 16, "R7 random page");
      rdsr(s); chk("R5 random status", s, exp_st());
    end

    summary();
    $finish;
  end
endmodule